// File: doc/BRIEF.md
# Low-Power Mode Clock Controller

This block sequences a small processor system between its run state and three sleep depths: light sleep, deep sleep and power-down. Software selects a depth on a two-bit request input and then pulses an entry strobe. The controller then drives the enables for the core clock, the peripheral clocks, the internal RC oscillator and its output gate, the watchdog oscillator and the brown-out detector. It also drives the flash power state and the analog power enable. Real gating cells, the oscillators and the power switches sit outside the block. Only their enables are produced here.

Each depth stops a different set of resources. Light sleep halts only the core clock. Deep sleep keeps the RC oscillator running, parks the flash in standby and shuts the analog blocks. It gates the RC output unless that output clocks the watchdog. Power-down stops every source except a selected watchdog oscillator and switches the flash off. In both deeper states the brown-out detector stays on if configured. Wake sources are qualified by a per-source enable mask. Light sleep returns to run on the next cycle. The deeper states pass through a waking phase: oscillator, flash and analog power come back first, and the core clock is released only after a parameterised number of settling cycles, which is longer after power-down. A sticky cause register records which enabled sources ended the last sleep.

Top module: `lpm_clk_ctrl`

## Requirements
- R1: Asynchronous active-low reset puts the block in run state, from any state. Run state means status 0, every enable high (the watchdog oscillator follows its select input), flash active, and the wake-cause register cleared.
- R2: Light sleep is entered when the strobe arrives in run with request 1. It clears only the core clock enable. Flash stays active (code 2), and the peripheral clocks, RC oscillator, brown-out detector and analog power stay on.
- R3: Deep sleep is entered when the strobe arrives in run with request 2. It clears the core and peripheral clocks and the analog power and keeps the RC oscillator on. Flash goes to standby (code 1). The RC output gate equals the input that marks the RC oscillator as the watchdog clock.
- R4: Power-down is entered when the strobe arrives in run with request 3. It clears the core and peripheral clocks, the RC oscillator and its output, and the analog power. Flash is off (code 0).
- R5: In deep sleep and power-down, the watchdog oscillator enable follows its select input and the brown-out enable follows its keep input.
- R6: In any sleep state, a source that is high while its mask bit is set starts the wake. A source whose mask bit is clear has no effect. From light sleep the state is run one cycle later.
- R7: A wake from deep sleep enters a waking phase (status 4) for DS_WAIT cycles before run. During this phase the RC oscillator, its output, flash (active), analog power and brown-out detector are on, and the core and peripheral clocks are off.
- R8: A wake from power-down enters the same waking phase for PD_WAIT cycles before run.
- R9: An entry strobe during the waking phase is ignored, even in its last cycle. The block lands in run, not in a sleep state.
- R10: The wake-cause register is loaded with the enabled, asserted sources when a wake starts. It keeps that value through run and later sleep entries until the next wake or a reset.
- R11: An entry strobe with request 0 leaves the block in run.
- R12: The status output encodes run 0, light sleep 1, deep sleep 2, power-down 3 and waking 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_req_i | input | 2 | Requested depth: 0 none, 1 light, 2 deep, 3 power-down |
| enter_i | input | 1 | Sleep entry strobe |
| wake_src_i | input | NW | Wake source levels |
| wake_en_i | input | NW | Per-source wake mask |
| irc_wdt_i | input | 1 | RC oscillator is the watchdog clock |
| wdosc_sel_i | input | 1 | Watchdog oscillator selected |
| bod_keep_i | input | 1 | Keep brown-out detector in deep states |
| core_clk_en_o | output | 1 | Core clock enable |
| periph_clk_en_o | output | 1 | Peripheral clock enable |
| irc_en_o | output | 1 | RC oscillator enable |
| irc_out_en_o | output | 1 | RC oscillator output gate |
| wdosc_en_o | output | 1 | Watchdog oscillator enable |
| bod_en_o | output | 1 | Brown-out detector enable |
| flash_mode_o | output | 2 | Flash: 0 off, 1 standby, 2 active |
| analog_en_o | output | 1 | Analog power enable |
| mode_o | output | 3 | Current state code |
| wake_cause_o | output | NW | Sticky wake cause |

## Verification
The settling counter expiring and a new entry strobe can fall on the same clock edge. The bench provokes this by holding the strobe high, with a sleep request, for the whole waking phase after a deep-sleep wake, so it is present on the edge where the count ends. It then judges that the status reads run and stays run once the strobe drops. The bench also asserts a wake source on the edge that enters sleep and checks that this source did not wake the block.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    typedef enum logic [2:0] {
        MD_RUN   = 3'd0,
        MD_SLEEP = 3'd1,
        MD_DEEP  = 3'd2,
        MD_PDOWN = 3'd3,
        MD_WAKE  = 3'd4
    } lpm_mode_e;

    typedef enum logic [1:0] {
        FL_OFF    = 2'd0,
        FL_STBY   = 2'd1,
        FL_ACTIVE = 2'd2
    } flash_e;

    localparam logic [1:0] REQ_RUN   = 2'd0;
    localparam logic [1:0] REQ_SLEEP = 2'd1;
    localparam logic [1:0] REQ_DEEP  = 2'd2;
    localparam logic [1:0] REQ_PDOWN = 2'd3;

    typedef struct packed {
        logic   core;
        logic   periph;
        logic   irc;
        logic   irc_out;
        logic   wdosc;
        logic   bod;
        flash_e flash;
        logic   analog;
    } pwr_ctl_t;

endpackage

// File: rtl/lpm_wake_qual.sv
module lpm_wake_qual #(
    parameter int NW = 4
) (
    input  logic [NW-1:0] src_i,
    input  logic [NW-1:0] en_i,
    output logic [NW-1:0] hit_vec_o,
    output logic          hit_o
);

    for (genvar g = 0; g < NW; g++) begin : g_mask
        assign hit_vec_o[g] = src_i[g] & en_i[g];
    end

    assign hit_o = |hit_vec_o;

endmodule

// File: rtl/lpm_wake_timer.sv
module lpm_wake_timer #(
    parameter int DS_WAIT = 4,
    parameter int PD_WAIT = 12,
    localparam int MAXW   = (DS_WAIT > PD_WAIT) ? DS_WAIT : PD_WAIT,
    localparam int CW     = (MAXW < 2) ? 1 : $clog2(MAXW)
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic load_i,
    input  logic from_pd_i,
    output logic done_o
);

    localparam logic [CW-1:0] DS_LOAD = CW'(DS_WAIT - 1);
    localparam logic [CW-1:0] PD_LOAD = CW'(PD_WAIT - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = from_pd_i ? PD_LOAD : DS_LOAD;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign done_o = (cnt_q == '0);

endmodule

// File: rtl/lpm_pwr_decode.sv
module lpm_pwr_decode
    import lpm_pkg::*;
(
    input  lpm_mode_e mode_i,
    input  logic      irc_wdt_i,
    input  logic      wdosc_sel_i,
    input  logic      bod_keep_i,
    output pwr_ctl_t  ctl_o
);

    always_comb begin
        ctl_o.core    = 1'b1;
        ctl_o.periph  = 1'b1;
        ctl_o.irc     = 1'b1;
        ctl_o.irc_out = 1'b1;
        ctl_o.wdosc   = wdosc_sel_i;
        ctl_o.bod     = 1'b1;
        ctl_o.flash   = FL_ACTIVE;
        ctl_o.analog  = 1'b1;
        unique case (mode_i)
            MD_RUN: begin
            end
            MD_SLEEP: begin
                ctl_o.core = 1'b0;
            end
            MD_DEEP: begin
                ctl_o.core    = 1'b0;
                ctl_o.periph  = 1'b0;
                ctl_o.irc_out = irc_wdt_i;
                ctl_o.bod     = bod_keep_i;
                ctl_o.flash   = FL_STBY;
                ctl_o.analog  = 1'b0;
            end
            MD_PDOWN: begin
                ctl_o.core    = 1'b0;
                ctl_o.periph  = 1'b0;
                ctl_o.irc     = 1'b0;
                ctl_o.irc_out = 1'b0;
                ctl_o.bod     = bod_keep_i;
                ctl_o.flash   = FL_OFF;
                ctl_o.analog  = 1'b0;
            end
            MD_WAKE: begin
                ctl_o.core   = 1'b0;
                ctl_o.periph = 1'b0;
            end
            default: begin
                ctl_o.core = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/lpm_clk_ctrl.sv
module lpm_clk_ctrl
    import lpm_pkg::*;
#(
    parameter int NW      = 4,
    parameter int DS_WAIT = 4,
    parameter int PD_WAIT = 12
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [1:0]    mode_req_i,
    input  logic          enter_i,
    input  logic [NW-1:0] wake_src_i,
    input  logic [NW-1:0] wake_en_i,
    input  logic          irc_wdt_i,
    input  logic          wdosc_sel_i,
    input  logic          bod_keep_i,
    output logic          core_clk_en_o,
    output logic          periph_clk_en_o,
    output logic          irc_en_o,
    output logic          irc_out_en_o,
    output logic          wdosc_en_o,
    output logic          bod_en_o,
    output logic [1:0]    flash_mode_o,
    output logic          analog_en_o,
    output logic [2:0]    mode_o,
    output logic [NW-1:0] wake_cause_o
);

    typedef struct packed {
        lpm_mode_e     mode;
        logic [NW-1:0] cause;
    } seq_t;

    seq_t          seq_d, seq_q;
    logic [NW-1:0] hit_vec;
    logic          hit;
    logic          tmr_load;
    logic          tmr_from_pd;
    logic          tmr_done;
    pwr_ctl_t      ctl;

    lpm_wake_qual #(.NW(NW)) u_qual (
        .src_i     (wake_src_i),
        .en_i      (wake_en_i),
        .hit_vec_o (hit_vec),
        .hit_o     (hit)
    );

    lpm_wake_timer #(.DS_WAIT(DS_WAIT), .PD_WAIT(PD_WAIT)) u_timer (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .load_i    (tmr_load),
        .from_pd_i (tmr_from_pd),
        .done_o    (tmr_done)
    );

    always_comb begin
        seq_d       = seq_q;
        tmr_load    = 1'b0;
        tmr_from_pd = 1'b0;
        unique case (seq_q.mode)
            MD_RUN: begin
                if (enter_i) begin
                    unique case (mode_req_i)
                        REQ_SLEEP: seq_d.mode = MD_SLEEP;
                        REQ_DEEP:  seq_d.mode = MD_DEEP;
                        REQ_PDOWN: seq_d.mode = MD_PDOWN;
                        default:   seq_d.mode = MD_RUN;
                    endcase
                end
            end
            MD_SLEEP: begin
                if (hit) begin
                    seq_d.mode  = MD_RUN;
                    seq_d.cause = hit_vec;
                end
            end
            MD_DEEP: begin
                if (hit) begin
                    seq_d.mode  = MD_WAKE;
                    seq_d.cause = hit_vec;
                    tmr_load    = 1'b1;
                end
            end
            MD_PDOWN: begin
                if (hit) begin
                    seq_d.mode  = MD_WAKE;
                    seq_d.cause = hit_vec;
                    tmr_load    = 1'b1;
                    tmr_from_pd = 1'b1;
                end
            end
            MD_WAKE: begin
                if (tmr_done) begin
                    seq_d.mode = MD_RUN;
                end
            end
            default: begin
                seq_d.mode = MD_RUN;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            seq_q.mode  <= MD_RUN;
            seq_q.cause <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    lpm_pwr_decode u_dec (
        .mode_i      (seq_q.mode),
        .irc_wdt_i   (irc_wdt_i),
        .wdosc_sel_i (wdosc_sel_i),
        .bod_keep_i  (bod_keep_i),
        .ctl_o       (ctl)
    );

    assign core_clk_en_o   = ctl.core;
    assign periph_clk_en_o = ctl.periph;
    assign irc_en_o        = ctl.irc;
    assign irc_out_en_o    = ctl.irc_out;
    assign wdosc_en_o      = ctl.wdosc;
    assign bod_en_o        = ctl.bod;
    assign flash_mode_o    = ctl.flash;
    assign analog_en_o     = ctl.analog;
    assign mode_o          = seq_q.mode;
    assign wake_cause_o    = seq_q.cause;

endmodule

// File: rtl/lpm_clk_ctrl_chk.sv
module lpm_clk_ctrl_chk #(
    parameter int NW = 4
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          enter_i,
    input logic [NW-1:0] wake_src_i,
    input logic [NW-1:0] wake_en_i,
    input logic          irc_wdt_i,
    input logic          core_clk_en_o,
    input logic          periph_clk_en_o,
    input logic          irc_en_o,
    input logic          irc_out_en_o,
    input logic [1:0]    flash_mode_o,
    input logic [2:0]    mode_o,
    input logic [NW-1:0] wake_cause_o
);

    p_sleep_core_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_o == 3'd1) |-> (!core_clk_en_o && periph_clk_en_o && flash_mode_o == 2'd2));

    p_deep_irc_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_o == 3'd2) |-> (irc_en_o && irc_out_en_o == irc_wdt_i && flash_mode_o == 2'd1));

    p_pdown_off_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_o == 3'd3) |-> (!irc_en_o && flash_mode_o == 2'd0));

    p_sleep_exit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_o == 3'd1 && |(wake_src_i & wake_en_i)) |=> (mode_o == 3'd0));

    p_wake_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_o == 3'd4) |-> (!core_clk_en_o && flash_mode_o == 2'd2 && irc_en_o));

    p_no_entry_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_o == 3'd4) |=> (mode_o == 3'd4 || mode_o == 3'd0));

    p_cause_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_o == 3'd0) |=> $stable(wake_cause_o));

    p_run_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_o == 3'd0 && !enter_i) |=> (mode_o == 3'd0));

endmodule

bind lpm_clk_ctrl lpm_clk_ctrl_chk #(.NW(NW)) u_chk (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .enter_i         (enter_i),
    .wake_src_i      (wake_src_i),
    .wake_en_i       (wake_en_i),
    .irc_wdt_i       (irc_wdt_i),
    .core_clk_en_o   (core_clk_en_o),
    .periph_clk_en_o (periph_clk_en_o),
    .irc_en_o        (irc_en_o),
    .irc_out_en_o    (irc_out_en_o),
    .flash_mode_o    (flash_mode_o),
    .mode_o          (mode_o),
    .wake_cause_o    (wake_cause_o)
);

// File: tb/lpm_clk_ctrl_tb.sv
module lpm_clk_ctrl_tb;

    localparam int NW  = 4;
    localparam int DSW = 4;
    localparam int PDW = 12;

    typedef struct packed {
        logic [1:0]    req;
        logic          irc_wdt;
        logic          wdsel;
        logic          bodk;
        logic [NW-1:0] en;
        logic [NW-1:0] masked;
        logic [NW-1:0] hit;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VEC [NV] = '{
        '{2'd1, 1'b0, 1'b0, 1'b0, 4'b0001, 4'b0010, 4'b0001},
        '{2'd2, 1'b1, 1'b1, 1'b1, 4'b0010, 4'b0101, 4'b0011},
        '{2'd2, 1'b0, 1'b0, 1'b0, 4'b1100, 4'b0011, 4'b1000},
        '{2'd3, 1'b1, 1'b1, 1'b0, 4'b0100, 4'b1000, 4'b0100},
        '{2'd3, 1'b0, 1'b0, 1'b1, 4'b1001, 4'b0110, 4'b1111},
        '{2'd1, 1'b1, 1'b1, 1'b1, 4'b0110, 4'b1001, 4'b0100}
    };

    logic          clk = 1'b0;
    logic          rst_ni = 1'b0;
    logic [1:0]    mode_req = 2'd0;
    logic          enter = 1'b0;
    logic [NW-1:0] wake_src = '0;
    logic [NW-1:0] wake_en = '0;
    logic          irc_wdt = 1'b0;
    logic          wdsel = 1'b0;
    logic          bodk = 1'b0;
    logic          core_en, periph_en, irc_en, irc_out, wdosc_en, bod_en, analog_en;
    logic [1:0]    flash_mode;
    logic [2:0]    mode;
    logic [NW-1:0] cause;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    lpm_clk_ctrl #(.NW(NW), .DS_WAIT(DSW), .PD_WAIT(PDW)) u_dut (
        .clk_i           (clk),
        .rst_ni          (rst_ni),
        .mode_req_i      (mode_req),
        .enter_i         (enter),
        .wake_src_i      (wake_src),
        .wake_en_i       (wake_en),
        .irc_wdt_i       (irc_wdt),
        .wdosc_sel_i     (wdsel),
        .bod_keep_i      (bodk),
        .core_clk_en_o   (core_en),
        .periph_clk_en_o (periph_en),
        .irc_en_o        (irc_en),
        .irc_out_en_o    (irc_out),
        .wdosc_en_o      (wdosc_en),
        .bod_en_o        (bod_en),
        .flash_mode_o    (flash_mode),
        .analog_en_o     (analog_en),
        .mode_o          (mode),
        .wake_cause_o    (cause)
    );

    // {core, periph, irc, irc_out, wdosc, bod, flash[1:0], analog}
    function automatic logic [8:0] exp_ctl(input int m, input logic iw, input logic ws, input logic bk);
        case (m)
            1:       return {1'b0, 1'b1, 1'b1, 1'b1, ws, 1'b1, 2'd2, 1'b1};
            2:       return {1'b0, 1'b0, 1'b1, iw,   ws, bk,   2'd1, 1'b0};
            3:       return {1'b0, 1'b0, 1'b0, 1'b0, ws, bk,   2'd0, 1'b0};
            4:       return {1'b0, 1'b0, 1'b1, 1'b1, ws, 1'b1, 2'd2, 1'b1};
            default: return {1'b1, 1'b1, 1'b1, 1'b1, ws, 1'b1, 2'd2, 1'b1};
        endcase
    endfunction

    function automatic logic [8:0] act_ctl();
        return {core_en, periph_en, irc_en, irc_out, wdosc_en, bod_en, flash_mode, analog_en};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        // R1: reset state
        chk("R1 mode", 32'(mode), 0);
        chk("R1 ctl", 32'(act_ctl()), 32'(exp_ctl(0, 1'b0, 1'b0, 1'b0)));
        chk("R1 cause", 32'(cause), 0);
        rst_ni = 1'b1;
        tick();

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            int   d;
            v = VEC[i];
            mode_req = v.req;
            irc_wdt  = v.irc_wdt;
            wdsel    = v.wdsel;
            bodk     = v.bodk;
            wake_en  = v.en;
            wake_src = v.hit;      // present on the entry edge: run ignores it (R6)
            enter    = 1'b1;
            tick();
            enter    = 1'b0;
            wake_src = '0;
            chk("R12 mode after entry", 32'(mode), 32'(v.req));
            chk(v.req == 2'd1 ? "R2 ctl" : (v.req == 2'd2 ? "R3 R5 ctl" : "R4 R5 ctl"),
                32'(act_ctl()), 32'(exp_ctl(int'(v.req), v.irc_wdt, v.wdsel, v.bodk)));
            tick();
            chk("R6 held asleep", 32'(mode), 32'(v.req));
            wake_src = v.masked;
            tick();
            chk("R6 masked source ignored", 32'(mode), 32'(v.req));
            wake_src = v.hit;
            tick();
            wake_src = '0;
            chk("R10 cause loaded", 32'(cause), 32'(v.hit & v.en));
            if (v.req == 2'd1) begin
                chk("R6 light sleep exit", 32'(mode), 0);
                chk("R6 run ctl", 32'(act_ctl()), 32'(exp_ctl(0, v.irc_wdt, v.wdsel, v.bodk)));
            end else begin
                d = (v.req == 2'd2) ? DSW : PDW;
                chk(v.req == 2'd2 ? "R7 waking" : "R8 waking", 32'(mode), 4);
                chk("R7 waking ctl", 32'(act_ctl()), 32'(exp_ctl(4, v.irc_wdt, v.wdsel, v.bodk)));
                repeat (d - 1) tick();
                chk(v.req == 2'd2 ? "R7 last wait cycle" : "R8 last wait cycle", 32'(mode), 4);
                tick();
                chk(v.req == 2'd2 ? "R7 run after wait" : "R8 run after wait", 32'(mode), 0);
                chk("R7 run ctl", 32'(act_ctl()), 32'(exp_ctl(0, v.irc_wdt, v.wdsel, v.bodk)));
            end
            tick();
            chk("R10 cause held in run", 32'(cause), 32'(v.hit & v.en));
        end

        // R11: strobe with request 0
        mode_req = 2'd0;
        enter = 1'b1;
        tick();
        enter = 1'b0;
        chk("R11 stays run", 32'(mode), 0);

        // R6/R10: wake sources in run leave cause untouched
        wake_en = 4'b1111;
        wake_src = 4'b1111;
        tick();
        wake_src = '0;
        chk("R10 run ignores wake", 32'(cause), 32'(4'b0100));

        // R9: strobe held through the whole deep wake, including the final edge
        irc_wdt = 1'b0; wdsel = 1'b0; bodk = 1'b0;
        wake_en = 4'b0001;
        mode_req = 2'd2;
        enter = 1'b1;
        tick();
        enter = 1'b0;
        chk("R3 deep entry", 32'(mode), 2);
        wake_src = 4'b0001;
        tick();
        wake_src = '0;
        mode_req = 2'd1;
        enter = 1'b1;
        chk("R9 waking", 32'(mode), 4);
        repeat (DSW) tick();
        enter = 1'b0;
        chk("R9 strobe ignored at end of wait", 32'(mode), 0);
        tick();
        chk("R9 still run", 32'(mode), 0);

        // R10: cause survives a later entry
        mode_req = 2'd3;
        enter = 1'b1;
        tick();
        enter = 1'b0;
        chk("R4 pdown entry", 32'(mode), 3);
        chk("R10 cause kept in sleep", 32'(cause), 32'(4'b0001));

        // R1: reset from power-down
        @(posedge clk);
        #1 rst_ni = 1'b0;
        #1;
        chk("R1 reset from pdown", 32'(mode), 0);
        chk("R1 reset clears cause", 32'(cause), 0);
        chk("R1 reset ctl", 32'(act_ctl()), 32'(exp_ctl(0, 1'b0, 1'b0, 1'b0)));
        tick();
        rst_ni = 1'b1;
        tick();
        chk("R1 run after release", 32'(mode), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule